// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a register-mapped real-time clock. It counts seconds, minutes, hours, day of month, month, year and weekday, every field in packed BCD, and advances by one second on each pulse of a one-second tick input while its run bit is set. Software sets the time by clearing the run bit, writing the time registers and setting the run bit again. To read a consistent time it writes the snapshot command, which freezes a copy of the six calendar fields for later reads.

A six-field alarm (seconds through year) is compared with the calendar on every counting tick. Sticky status flags record second, minute, hour and day boundaries, an alarm match and a power-up event. Software clears each flag by writing a one to its bit. One interrupt line combines a periodic source, whose period is chosen in the interrupt-enable register, with the alarm source.

Access goes through a synchronous byte-wide bus. Writes take effect at the clock edge. Read data is a combinational function of the address and the registered state.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the clock is stopped, the time reads 00:00:00 on day 01 of month 01, year 00, weekday 0. The interrupt-enable and control registers read 0x00, the status register reads 0x80 (power-up flag only) and irq is low.
- R2: Address map: 0x00 to 0x06 hold second, minute, hour, day, month, year and weekday; 0x07 to 0x0C hold the alarm second through alarm year; 0x0D is control, 0x0E is status, 0x0F is interrupt enable, 0x10 and 0x11 are two plain storage bytes. Control bits 1, 2, 3 and 5 read back as written and bits 4, 6 and 7 read 0. Interrupt enable keeps bits [3:0] and reads 0 above them. Alarm and storage bytes read back whole. Every other address reads 0x00.
- R3: The calendar advances by one second per tick only while control bit 0 (run) is 1, and status bit 1 mirrors the run bit. A tick seen in the cycle that writes the run bit uses the run value held before that write.
- R4: Seconds and minutes wrap from 0x59 to 0x00 and carry. Hours wrap from 0x23 to 0x00, carrying into the day and into the weekday, which counts 0 to 6 and wraps to 0.
- R5: The day wraps to 0x01 after the last day of its month: 31, 30 for months 04, 06, 09 and 11, 28 for month 02, or 29 for month 02 when the year is divisible by 4 (year 00 included). Month wraps from 0x12 to 0x01 and carries into the year, which wraps from 0x99 to 0x00.
- R6: Reads of 0x00 to 0x05 return a shadow copy. Writing control with bit 6 set loads the shadow from the calendar value held before that edge. A direct write to one of those six registers updates the live field and its shadow together.
- R7: Status bit 2 sets on every counting tick, bit 3 when the seconds wrap, bit 4 when the minutes wrap and bit 5 when the hours wrap. Each stays set until software clears it.
- R8: Status bit 6 (alarm) sets on a counting tick whose resulting seconds, minutes, hours, day, month and year all equal the alarm registers.
- R9: Writing status clears each of bits 2 to 7 whose written bit is 1 and leaves the rest. A flag that sets in the same cycle stays set. The power-up flag is set only by reset.
- R10: Interrupt-enable bits [1:0] pick the periodic flag (0 second, 1 minute, 2 hour, 3 day), bit 2 enables that periodic source and bit 3 enables the alarm source. irq is high exactly while an enabled source has its flag set.
- R11: When a time register is written in the same cycle as a counting tick, the written field takes the written value and the other fields advance as the tick dictates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq | output | 1 | Level interrupt request |

## Verification
The bench uses the default ADDR_W of 5, which covers the whole map plus unmapped addresses up to 0x1F for the read-as-zero check. Because the time registers can be loaded directly, every month end, the leap-year February, the 99-to-00 year wrap and the alarm match are each reached within one or two ticks rather than after simulated years. A behavioural calendar model in integers predicts the read data at the driven address and the irq level on every clock. Hand-computed checks cover same-cycle write and tick collisions.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

    localparam int CAL_FIELDS = 7;
    localparam int ALM_FIELDS = 6;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;
    localparam int F_WDAY = 6;

    localparam int A_TIME_BASE = 0;
    localparam int A_ALM_BASE  = 7;
    localparam int A_CTRL      = 13;
    localparam int A_STAT      = 14;
    localparam int A_IEN       = 15;
    localparam int A_STORE_LO  = 16;
    localparam int A_STORE_HI  = 17;

    localparam int          RUN_BIT   = 0;
    localparam int          SNAP_BIT  = 6;
    localparam logic [7:0]  CTRL_KEEP = 8'h2E;

    localparam int IEN_W     = 4;
    localparam int IEN_TMR   = 2;
    localparam int IEN_ALM   = 3;

    localparam int NFLAG     = 6;
    localparam int FLG_ALM   = 4;
    localparam int FLG_PWR   = 5;
    localparam int FLG_LSB   = 2;

    typedef logic [CAL_FIELDS-1:0][7:0] cal_t;
    typedef logic [ALM_FIELDS-1:0][7:0] alm_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9)
            return {v[7:4] + 4'h1, 4'h0};
        else
            return {v[7:4], v[3:0] + 4'h1};
    endfunction

    function automatic logic leap_year(input logic [7:0] y);
        logic [7:0] bin;
        bin = ({4'h0, y[7:4]} * 8'd10) + {4'h0, y[3:0]};
        return (bin[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic [7:0] y);
        case (mon)
            8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_cal_step.sv
`timescale 1ns/1ps
module rtc_cal_step
    import rtc_cal_pkg::*;
(
    input  cal_t       cur,
    input  logic       adv,
    output cal_t       nxt,
    output logic [3:0] evt
);
    logic sec_end, min_end, hour_end, day_end, mon_end, year_end, wday_end;
    logic c_min, c_hour, c_day, c_mon, c_year;

    always_comb begin
        sec_end  = (cur[F_SEC]  == 8'h59);
        min_end  = (cur[F_MIN]  == 8'h59);
        hour_end = (cur[F_HOUR] == 8'h23);
        day_end  = (cur[F_DAY]  == month_last_day(cur[F_MON], cur[F_YEAR]));
        mon_end  = (cur[F_MON]  == 8'h12);
        year_end = (cur[F_YEAR] == 8'h99);
        wday_end = (cur[F_WDAY] == 8'h06);

        c_min  = adv    & sec_end;
        c_hour = c_min  & min_end;
        c_day  = c_hour & hour_end;
        c_mon  = c_day  & day_end;
        c_year = c_mon  & mon_end;

        nxt = cur;
        if (adv)
            nxt[F_SEC]  = sec_end  ? 8'h00 : bcd_inc(cur[F_SEC]);
        if (c_min)
            nxt[F_MIN]  = min_end  ? 8'h00 : bcd_inc(cur[F_MIN]);
        if (c_hour)
            nxt[F_HOUR] = hour_end ? 8'h00 : bcd_inc(cur[F_HOUR]);
        if (c_day) begin
            nxt[F_DAY]  = day_end  ? 8'h01 : bcd_inc(cur[F_DAY]);
            nxt[F_WDAY] = wday_end ? 8'h00 : cur[F_WDAY] + 8'h01;
        end
        if (c_mon)
            nxt[F_MON]  = mon_end  ? 8'h01 : bcd_inc(cur[F_MON]);
        if (c_year)
            nxt[F_YEAR] = year_end ? 8'h00 : bcd_inc(cur[F_YEAR]);

        evt = {c_day, c_hour, c_min, adv};
    end
endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match
    import rtc_cal_pkg::*;
(
    input  cal_t  t,
    input  alm_t  alm,
    output logic  hit
);
    logic [ALM_FIELDS-1:0] eq;

    for (genvar g = 0; g < ALM_FIELDS; g++) begin : g_field
        assign eq[g] = (t[g] == alm[g]);
    end

    assign hit = &eq;
endmodule

// File: rtl/rtc_flag_bank.sv
`timescale 1ns/1ps
module rtc_flag_bank #(
    parameter int              NF      = 6,
    parameter logic [NF-1:0]   RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] flags
);
    logic [NF-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = (flags_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_q <= RST_VAL;
        else
            flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/rtc_bcd_calendar.sv
`timescale 1ns/1ps
module rtc_bcd_calendar
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    localparam logic [NFLAG-1:0] FLAG_RST = NFLAG'(1) << FLG_PWR;

    typedef struct packed {
        cal_t              live;
        alm_t              shadow;
        alm_t              alarm;
        logic              run;
        logic [7:0]        ctrl_keep;
        logic [IEN_W-1:0]  ien;
        logic [7:0]        store_lo;
        logic [7:0]        store_hi;
    } regs_t;

    regs_t            st_d, st_q;
    cal_t             step_nxt;
    logic [3:0]       step_evt;
    logic             advance;
    logic             alarm_hit;
    logic [NFLAG-1:0] flag_set, flag_clr, flags;
    logic             periodic_sel;

    assign advance = tick_1hz & st_q.run;

    rtc_cal_step u_step (
        .cur (st_q.live),
        .adv (advance),
        .nxt (step_nxt),
        .evt (step_evt)
    );

    // next-state of every register
    always_comb begin
        st_d      = st_q;
        st_d.live = step_nxt;
        if (bus_we) begin
            for (int i = 0; i < CAL_FIELDS; i++) begin
                if (bus_addr == ADDR_W'(A_TIME_BASE + i))
                    st_d.live[i] = bus_wdata;
            end
            for (int i = 0; i < ALM_FIELDS; i++) begin
                if (bus_addr == ADDR_W'(A_TIME_BASE + i))
                    st_d.shadow[i] = bus_wdata;
                if (bus_addr == ADDR_W'(A_ALM_BASE + i))
                    st_d.alarm[i] = bus_wdata;
            end
            if (bus_addr == ADDR_W'(A_CTRL)) begin
                st_d.run       = bus_wdata[RUN_BIT];
                st_d.ctrl_keep = bus_wdata & CTRL_KEEP;
                if (bus_wdata[SNAP_BIT])
                    st_d.shadow = st_q.live[ALM_FIELDS-1:0];
            end
            if (bus_addr == ADDR_W'(A_IEN))
                st_d.ien = bus_wdata[IEN_W-1:0];
            if (bus_addr == ADDR_W'(A_STORE_LO))
                st_d.store_lo = bus_wdata;
            if (bus_addr == ADDR_W'(A_STORE_HI))
                st_d.store_hi = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q                 <= '0;
            st_q.live[F_DAY]     <= 8'h01;
            st_q.live[F_MON]     <= 8'h01;
            st_q.shadow[F_DAY]   <= 8'h01;
            st_q.shadow[F_MON]   <= 8'h01;
        end else begin
            st_q <= st_d;
        end
    end

    // alarm compares the value the calendar takes at this edge
    rtc_alarm_match u_alarm (
        .t   (st_d.live),
        .alm (st_q.alarm),
        .hit (alarm_hit)
    );

    always_comb begin
        flag_set          = '0;
        flag_set[3:0]     = step_evt;
        flag_set[FLG_ALM] = advance & alarm_hit;
        flag_clr          = '0;
        if (bus_we && bus_addr == ADDR_W'(A_STAT))
            flag_clr = bus_wdata[FLG_LSB +: NFLAG];
    end

    rtc_flag_bank #(
        .NF      (NFLAG),
        .RST_VAL (FLAG_RST)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flags)
    );

    always_comb begin
        periodic_sel = flags[st_q.ien[1:0]];
        irq = (st_q.ien[IEN_TMR] & periodic_sel) |
              (st_q.ien[IEN_ALM] & flags[FLG_ALM]);
    end

    // read path
    always_comb begin
        bus_rdata = 8'h00;
        for (int i = 0; i < ALM_FIELDS; i++) begin
            if (bus_addr == ADDR_W'(A_TIME_BASE + i))
                bus_rdata = st_q.shadow[i];
            if (bus_addr == ADDR_W'(A_ALM_BASE + i))
                bus_rdata = st_q.alarm[i];
        end
        if (bus_addr == ADDR_W'(A_TIME_BASE + F_WDAY))
            bus_rdata = st_q.live[F_WDAY];
        if (bus_addr == ADDR_W'(A_CTRL))
            bus_rdata = st_q.ctrl_keep | {7'h00, st_q.run};
        if (bus_addr == ADDR_W'(A_STAT))
            bus_rdata = {flags, st_q.run, 1'b0};
        if (bus_addr == ADDR_W'(A_IEN))
            bus_rdata = {{(8-IEN_W){1'b0}}, st_q.ien};
        if (bus_addr == ADDR_W'(A_STORE_LO))
            bus_rdata = st_q.store_lo;
        if (bus_addr == ADDR_W'(A_STORE_HI))
            bus_rdata = st_q.store_hi;
    end

endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick_1hz,
    input logic             bus_we,
    input logic             irq,
    input logic             run_q,
    input cal_t             live_q,
    input logic [NFLAG-1:0] flags
);
    assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !bus_we) |=> $stable(live_q));

    assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick_1hz && !bus_we && live_q[F_SEC][3:0] != 4'h9)
        |=> (live_q[F_SEC] == $past(live_q[F_SEC]) + 8'h01));

    assert_hour_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q[F_HOUR] <= 8'h23) && (live_q[F_WDAY] <= 8'h06));

    assert_sec_digits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q[F_SEC][3:0] <= 4'h9) && (live_q[F_SEC] <= 8'h59));

    assert_alarm_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_ALM]) |-> $past(tick_1hz && run_q));

    assert_pwr_only_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[FLG_PWR] |=> !flags[FLG_PWR]);

    assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags[FLG_ALM:0] != '0));
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .bus_we   (bus_we),
    .irq      (irq),
    .run_q    (st_q.run),
    .live_q   (st_q.live),
    .flags    (flags)
);

// File: tb/tb_rtc_bcd_calendar.sv
`timescale 1ns/1ps
module tb_rtc_bcd_calendar;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_tick = 1'b0;
    logic [4:0] b_addr = '0;
    logic       b_we = 1'b0;
    logic [7:0] b_wd = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rtc_bcd_calendar #(.ADDR_W(5)) dut (
        .clk (clk), .rst_n (rst_n), .tick_1hz (b_tick),
        .bus_addr (b_addr), .bus_we (b_we), .bus_wdata (b_wd),
        .bus_rdata (bus_rdata), .irq (irq)
    );

    // ---------------- behavioural model ----------------
    int m_t[7];      // binary sec,min,hour,day,mon,year,wday
    int m_sh[6];     // BCD bytes
    int m_al[6];
    int m_run, m_keep, m_ien, m_lo, m_hi, m_fl;

    function automatic int to_bcd(int b);
        return ((b / 10) << 4) | (b % 10);
    endfunction
    function automatic int from_bcd(int v);
        return (v >> 4) * 10 + (v & 15);
    endfunction
    function automatic int mdays(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic m_reset();
        m_t = '{0, 0, 0, 1, 1, 0, 0};
        m_sh = '{0, 0, 0, 1, 1, 0};
        m_al = '{0, 0, 0, 0, 0, 0};
        m_run = 0; m_keep = 0; m_ien = 0; m_lo = 0; m_hi = 0;
        m_fl = 32;
    endtask

    task automatic m_step();
        int n[7];
        int ev, a, wd, clr;
        bit adv, hit;
        a = b_addr; wd = b_wd; ev = 0; clr = 0;
        n = m_t;
        adv = b_tick && (m_run != 0);
        if (adv) begin
            ev |= 1; n[0]++;
            if (n[0] == 60) begin
                n[0] = 0; ev |= 2; n[1]++;
                if (n[1] == 60) begin
                    n[1] = 0; ev |= 4; n[2]++;
                    if (n[2] == 24) begin
                        n[2] = 0; ev |= 8; n[6] = (n[6] + 1) % 7; n[3]++;
                        if (n[3] > mdays(n[4], n[5])) begin
                            n[3] = 1; n[4]++;
                            if (n[4] == 13) begin
                                n[4] = 1; n[5] = (n[5] + 1) % 100;
                            end
                        end
                    end
                end
            end
        end
        if (b_we && a <= 6) begin
            n[a] = from_bcd(wd);
            if (a <= 5) m_sh[a] = wd;
        end
        hit = adv;
        for (int i = 0; i < 6; i++)
            if (to_bcd(n[i]) != m_al[i]) hit = 0;
        if (b_we) begin
            if (a >= 7 && a <= 12) m_al[a-7] = wd;
            if (a == 13) begin
                m_run = wd & 1; m_keep = wd & 8'h2E;
                if ((wd & 8'h40) != 0)
                    for (int i = 0; i < 6; i++) m_sh[i] = to_bcd(m_t[i]);
            end
            if (a == 14) clr = (wd >> 2) & 63;
            if (a == 15) m_ien = wd & 15;
            if (a == 16) m_lo = wd;
            if (a == 17) m_hi = wd;
        end
        m_fl = ((m_fl & ~clr) | ev | (hit ? 16 : 0)) & 63;
        m_t = n;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_reset();
        else        m_step();
    end

    function automatic int m_read(int a);
        if (a <= 5) return m_sh[a];
        if (a == 6) return to_bcd(m_t[6]);
        if (a >= 7 && a <= 12) return m_al[a-7];
        if (a == 13) return m_keep | m_run;
        if (a == 14) return (m_fl << 2) | (m_run << 1);
        if (a == 15) return m_ien;
        if (a == 16) return m_lo;
        if (a == 17) return m_hi;
        return 0;
    endfunction

    function automatic int m_irq();
        int sel;
        sel = (m_fl >> (m_ien & 3)) & 1;
        return (((m_ien >> 2) & 1) & sel) | (((m_ien >> 3) & 1) & ((m_fl >> 4) & 1));
    endfunction

    function automatic string tag_for(int a);
        if (a <= 5) return "R6";
        if (a == 6) return "R4";
        if (a == 14) return "R9";
        return "R2";
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(int a, bit we, int wd, bit tk);
        b_addr = 5'(a); b_we = we; b_wd = 8'(wd); b_tick = tk;
        @(negedge clk);
        check(tag_for(a), bus_rdata, m_read(a));
        check("R10", irq, m_irq());
        b_we = 1'b0; b_tick = 1'b0;
    endtask

    task automatic wr(int a, int d);
        cyc(a, 1'b1, d, 1'b0);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cyc(14, 1'b0, 0, 1'b1);
    endtask

    task automatic rd(int a, int exp, string tag);
        b_addr = 5'(a); b_we = 1'b0;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic set_time(int h, int mi, int s, int d, int mo, int y, int w);
        wr(13, 8'h00);
        wr(0, s); wr(1, mi); wr(2, h); wr(3, d); wr(4, mo); wr(5, y); wr(6, w);
    endtask

    task automatic roll_day(int d, int mo, int y, int exp_d, int exp_mo, int exp_y);
        set_time(8'h23, 8'h59, 8'h59, d, mo, y, 8'h02);
        wr(13, 8'h01);
        ticks(1);
        wr(13, 8'h41);
        rd(3, exp_d, "R5 day");
        rd(4, exp_mo, "R5 month");
        rd(5, exp_y, "R5 year");
        rd(2, 8'h00, "R4 hour wrap");
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog R1: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, 8'h00, "R1 sec"); rd(2, 8'h00, "R1 hour");
        rd(3, 8'h01, "R1 day"); rd(4, 8'h01, "R1 month");
        rd(5, 8'h00, "R1 year"); rd(6, 8'h00, "R1 wday");
        rd(13, 8'h00, "R1 ctrl"); rd(14, 8'h80, "R1 status");
        rd(15, 8'h00, "R1 ien");
        check("R1 irq", irq, 0);

        // R3 stopped clock ignores ticks
        ticks(3);
        rd(14, 8'h80, "R3 no tick flag while stopped");
        wr(13, 8'h40);
        rd(0, 8'h00, "R3 stopped seconds");
        wr(13, 8'h01);
        rd(14, 8'h82, "R3 run mirrored");
        ticks(3);
        wr(13, 8'h41);
        rd(0, 8'h03, "R3 three ticks");
        rd(14, 8'h86, "R7 second flag");

        // R9 write-one-to-clear
        wr(14, 8'h04); rd(14, 8'h82, "R9 clear second flag");
        wr(14, 8'h00); rd(14, 8'h82, "R9 zero write no effect");
        wr(14, 8'h80); rd(14, 8'h02, "R9 clear power-up");

        // R4 / R5 / R7 cascade through non-leap February
        set_time(8'h23, 8'h59, 8'h58, 8'h28, 8'h02, 8'h23, 8'h06);
        wr(13, 8'h01);
        ticks(2);
        wr(13, 8'h41);
        rd(0, 8'h00, "R4 sec"); rd(1, 8'h00, "R4 min"); rd(2, 8'h00, "R4 hour");
        rd(3, 8'h01, "R5 day after Feb 28"); rd(4, 8'h03, "R5 month");
        rd(5, 8'h23, "R5 year kept"); rd(6, 8'h00, "R4 weekday wrap");
        rd(14, 8'h3E, "R7 all boundary flags");
        wr(14, 8'hFC);

        // R5 month lengths, leap year, century wrap
        roll_day(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24);
        roll_day(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24);
        roll_day(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00);
        roll_day(8'h30, 8'h04, 8'h24, 8'h01, 8'h05, 8'h24);
        roll_day(8'h30, 8'h01, 8'h24, 8'h31, 8'h01, 8'h24);
        roll_day(8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00);

        // R6 snapshot freezes reads
        ticks(2);
        rd(0, 8'h00, "R6 frozen seconds");
        rd(13, 8'h01, "R6 snapshot bit reads 0");
        wr(13, 8'h41);
        rd(0, 8'h02, "R6 refreshed seconds");
        wr(1, 8'h45);
        rd(1, 8'h45, "R6 direct write updates shadow");

        // R2 map and stored bits
        wr(13, 8'hFF); rd(13, 8'h2F, "R2 control kept bits");
        wr(16, 8'hA5); rd(16, 8'hA5, "R2 store low");
        wr(17, 8'h3C); rd(17, 8'h3C, "R2 store high");
        wr(15, 8'hF3); rd(15, 8'h03, "R2 ien upper bits");
        wr(10, 8'h15); rd(10, 8'h15, "R2 alarm day");
        rd(21, 8'h00, "R2 unmapped");
        wr(15, 8'h00);

        // R8 / R10 alarm
        wr(14, 8'hFC);
        set_time(8'h12, 8'h30, 8'h45, 8'h15, 8'h06, 8'h25, 8'h03);
        wr(7, 8'h47); wr(8, 8'h30); wr(9, 8'h12);
        wr(10, 8'h15); wr(11, 8'h06); wr(12, 8'h25);
        wr(15, 8'h08);
        wr(13, 8'h01);
        ticks(1);
        rd(14, 8'h06, "R8 no match yet");
        check("R10 alarm irq low", irq, 0);
        ticks(1);
        rd(14, 8'h46, "R8 alarm flag");
        check("R10 alarm irq high", irq, 1);
        wr(14, 8'h40);
        check("R10 irq drops on clear", irq, 0);

        // R10 periodic selection
        wr(15, 8'h05);
        wr(14, 8'hFC);
        wr(0, 8'h58);
        ticks(1);
        check("R10 minute period, second only", irq, 0);
        ticks(1);
        check("R10 minute period fires", irq, 1);
        wr(15, 8'h04);
        check("R10 second period", irq, 1);
        wr(14, 8'h04);
        check("R10 minute flag not selected", irq, 0);

        // R11 write and tick together (time now 12:31:00)
        cyc(1, 1'b1, 8'h20, 1'b1);
        wr(13, 8'h41);
        rd(0, 8'h01, "R11 other field advanced");
        rd(1, 8'h20, "R11 written minute");
        cyc(0, 1'b1, 8'h30, 1'b1);
        wr(13, 8'h41);
        rd(0, 8'h30, "R11 written second wins");

        // R9 set wins over clear
        wr(14, 8'hFC);
        cyc(14, 1'b1, 8'h04, 1'b1);
        rd(14, 8'h06, "R9 set beats clear");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule